// File: doc/BRIEF.md
# Partitioned Add/Subtract and Compare-Mask Unit

This block is a SIMD integer unit for a datapath. It takes two 64-bit operands and treats each as a set of independent lanes: four lanes of 16 bits or two lanes of 32 bits. It can add or subtract the lanes, and each lane wraps within its own width. It can also compare matching lanes under one of four predicates. A compare does not fill each lane with ones. It packs one pass/fail bit per lane into the low bits of a result that is otherwise zero, so the result can serve directly as a small lane mask.

A narrow mode uses only the low 32-bit word of each operand. That word holds two 16-bit lanes, or one 32-bit lane when the wide lane size is selected. In narrow mode the upper half of the result is zero. Operations are issued with a valid strobe. The result is registered and appears one clock later together with an output valid. Between issues the result holds its value.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is applied, and until the first issue after reset, `out_valid` is 0 and `result` is all zeros.
- R2: An operation issued with `in_valid`=1 appears on `result` with `out_valid`=1 after exactly one rising clock edge. When `in_valid`=0, `result` keeps its previous value and `out_valid` is 0 on the next cycle.
- R3: With `op_code`=00 (add) and `wide_lanes`=0, each 16-bit lane k (bits 16k+15:16k) of `result` is (a_k + b_k) mod 2^16. No carry passes into lane k+1.
- R4: With `wide_lanes`=1, add and subtract work on two 32-bit lanes (bits 31:0 and 63:32). The carry from bit 15 propagates into bit 16, but no carry passes from bit 31 into bit 32.
- R5: With `op_code`=01 (subtract), each lane of `result` is (a_k - b_k) modulo the lane width. A borrow never crosses a lane boundary.
- R6: With `narrow`=1, only bits 31:0 of the operands are used. That word holds two 16-bit lanes, or one 32-bit lane when `wide_lanes`=1. Bits 63:32 of `result` are 0 for every operation.
- R7: With `op_code`=10 (compare), `pred` selects the test of operand A against operand B, with lane values taken as unsigned: 000 greater-than, 001 equal, 010 less-or-equal, 011 not-equal.
- R8: In a 16-bit-lane compare, bit k of `result` (k=0..3) is 1 exactly when lane k passes the predicate, and bits 63:4 are 0.
- R9: In a 32-bit-lane compare, bits 0 and 1 of `result` report lanes 0 and 1, and bits 63:2 are 0.
- R10: In a narrow compare, only the lanes within bits 31:0 report. These are bits 1:0 for 16-bit lanes and bit 0 for a 32-bit lane. Every other result bit is 0.
- R11: `op_code`=11, or a compare with `pred` in 100..111, gives an all-zero `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Issue strobe; loads the result register |
| wide_lanes | input | 1 | Lane size: 0 = 16-bit lanes, 1 = 32-bit lanes |
| narrow | input | 1 | 1 = use only the low 32-bit word of the operands |
| op_code | input | 2 | 00 add, 01 subtract, 10 compare, 11 no operation (zero result) |
| pred | input | 3 | Compare predicate: 000 gt, 001 eq, 010 le, 011 ne, others invalid |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Lane sums/differences or packed compare mask |

## Verification
The cut in the carry chain at a lane boundary and the wrap of the lane below it happen in the same cycle. The bench provokes this with lanes of all ones plus one under both lane sizes. In 32-bit mode the carry out of bit 15 must reach bit 16, and in 16-bit mode it must be dropped. In a 32-bit compare, the high-half equality and the low-half ordering also meet in one cycle. Operands with equal upper halves and differing lower halves test that. Every result is judged against a lane-by-lane model written in the bench from the requirements.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_NONE = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PR_GT = 3'd0,
    PR_EQ = 3'd1,
    PR_LE = 3'd2,
    PR_NE = 3'd3
  } pred_e;

endpackage

// File: rtl/simd_rst_sync.sv
module simd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int WIDE_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              wide_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int NSEG = DATA_W / SEG_W;
  localparam int WSEG = WIDE_W / SEG_W;

  // carry[k]: carry out of segment k-1 into segment k
  logic [NSEG-1:0] carry;
  assign carry[0] = sub_i;

  genvar k;
  generate
    for (k = 0; k < NSEG; k++) begin : g_seg
      logic              cin;
      logic [SEG_W-1:0]  b_eff;
      assign b_eff = b_i[k*SEG_W +: SEG_W] ^ {SEG_W{sub_i}};
      if ((k % WSEG) == 0) begin : g_start
        // segment opens a lane in both lane sizes
        assign cin = sub_i;
      end else begin : g_mid
        // chain only when segments belong to one wide lane
        assign cin = wide_i ? carry[k] : sub_i;
      end
      if (k < NSEG - 1) begin : g_chain
        logic [SEG_W:0] s;
        assign s = {1'b0, a_i[k*SEG_W +: SEG_W]} + {1'b0, b_eff}
                 + {{SEG_W{1'b0}}, cin};
        assign sum_o[k*SEG_W +: SEG_W] = s[SEG_W-1:0];
        assign carry[k+1] = s[SEG_W];
      end else begin : g_last
        assign sum_o[k*SEG_W +: SEG_W] = a_i[k*SEG_W +: SEG_W] + b_eff
                                       + {{(SEG_W-1){1'b0}}, cin};
      end
    end
  endgenerate
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_lane_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int WIDE_W = 32
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic                     wide_i,
  input  logic                     narrow_i,
  input  logic [2:0]               pred_i,
  output logic                     pred_ok_o,
  output logic [DATA_W/SEG_W-1:0]  mask_o
);
  localparam int NSEG  = DATA_W / SEG_W;
  localparam int WSEG  = WIDE_W / SEG_W;
  localparam int NWIDE = DATA_W / WIDE_W;

  logic [NSEG-1:0]  seg_gt, seg_eq;
  logic [NWIDE-1:0] w_gt, w_eq;
  logic [NSEG-1:0]  lane_gt, lane_eq, hit;

  genvar k;
  generate
    for (k = 0; k < NSEG; k++) begin : g_seg
      assign seg_gt[k] = a_i[k*SEG_W +: SEG_W] > b_i[k*SEG_W +: SEG_W];
      assign seg_eq[k] = a_i[k*SEG_W +: SEG_W] == b_i[k*SEG_W +: SEG_W];
    end
  endgenerate

  // Merge segment results into wide lanes, low segment first.
  always_comb begin
    for (int j = 0; j < NWIDE; j++) begin
      w_gt[j] = 1'b0;
      w_eq[j] = 1'b1;
      for (int s = 0; s < WSEG; s++) begin
        w_gt[j] = seg_gt[j*WSEG+s] | (seg_eq[j*WSEG+s] & w_gt[j]);
        w_eq[j] = w_eq[j] & seg_eq[j*WSEG+s];
      end
    end
  end

  always_comb begin
    lane_gt = '0;
    lane_eq = '0;
    if (wide_i) begin
      lane_gt[NWIDE-1:0] = w_gt;
      lane_eq[NWIDE-1:0] = w_eq;
    end else begin
      lane_gt = seg_gt;
      lane_eq = seg_eq;
    end
  end

  always_comb begin
    pred_ok_o = 1'b1;
    case (pred_i)
      PR_GT:   hit = lane_gt;
      PR_EQ:   hit = lane_eq;
      PR_LE:   hit = ~lane_gt;
      PR_NE:   hit = ~lane_eq;
      default: begin
        hit       = '0;
        pred_ok_o = 1'b0;
      end
    endcase
  end

  // Keep only the lanes that exist in the selected shape.
  always_comb begin
    int lim;
    if (wide_i) lim = narrow_i ? NWIDE / 2 : NWIDE;
    else        lim = narrow_i ? NSEG / 2  : NSEG;
    for (int i = 0; i < NSEG; i++) begin
      mask_o[i] = hit[i] & (i < lim);
    end
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_lane_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int WIDE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              wide_lanes,
  input  logic              narrow,
  input  logic [1:0]        op_code,
  input  logic [2:0]        pred,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NSEG   = DATA_W / SEG_W;
  localparam int NWIDE  = DATA_W / WIDE_W;
  localparam int HALF_W = DATA_W / 2;

  logic              rst_sync_n;
  logic [DATA_W-1:0] sum;
  logic [NSEG-1:0]   mask;
  logic              pred_ok;
  logic [DATA_W-1:0] res_d, res_q;
  logic              valid_q;
  logic              cmp_d, cmp_q, wide_q, narrow_q, bad_d, bad_q;

  simd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  simd_lane_addsub #(.DATA_W(DATA_W), .SEG_W(SEG_W), .WIDE_W(WIDE_W)) u_addsub (
    .a_i    (op_a),
    .b_i    (op_b),
    .wide_i (wide_lanes),
    .sub_i  (op_code == OP_SUB),
    .sum_o  (sum)
  );

  simd_lane_cmp #(.DATA_W(DATA_W), .SEG_W(SEG_W), .WIDE_W(WIDE_W)) u_cmp (
    .a_i       (op_a),
    .b_i       (op_b),
    .wide_i    (wide_lanes),
    .narrow_i  (narrow),
    .pred_i    (pred),
    .pred_ok_o (pred_ok),
    .mask_o    (mask)
  );

  // Next-state selection
  always_comb begin
    res_d = '0;
    cmp_d = (op_code == OP_CMP);
    bad_d = (op_code == OP_NONE) || (cmp_d && !pred_ok);
    if (op_code == OP_ADD || op_code == OP_SUB) begin
      res_d = sum;
    end else if (cmp_d && pred_ok) begin
      res_d = {{(DATA_W-NSEG){1'b0}}, mask};
    end
    if (narrow) res_d[DATA_W-1:HALF_W] = '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q    <= '0;
      valid_q  <= 1'b0;
      cmp_q    <= 1'b0;
      wide_q   <= 1'b0;
      narrow_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q    <= res_d;
        cmp_q    <= cmp_d;
        wide_q   <= wide_lanes;
        narrow_q <= narrow;
        bad_q    <= bad_d;
      end
    end
  end

  assign result    = res_q;
  assign out_valid = valid_q;

  // Assertions
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(result) && !out_valid));

  p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && narrow_q) |-> (result[DATA_W-1:HALF_W] == '0));

  p_cmp16_mask_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && cmp_q) |-> (result[DATA_W-1:NSEG] == '0));

  p_cmp32_mask_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && cmp_q && wide_q) |-> (result[DATA_W-1:NWIDE] == '0));

  p_bad_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && bad_q) |-> (result == '0));
endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, wide_lanes, narrow;
  logic [1:0]  op_code;
  logic [2:0]  pred;
  logic [63:0] op_a, op_b;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  simd_lane_alu u_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_lanes(wide_lanes),
    .narrow(narrow), .op_code(op_code), .pred(pred), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic w, input logic n,
                                        input logic [1:0] op, input logic [2:0] p);
    logic [63:0] r = 64'd0;
    int lw = w ? 32 : 16;
    int lanes = (n ? 32 : 64) / lw;
    logic [63:0] m = (64'd1 << lw) - 64'd1;
    if (op == 2'b11) return 64'd0;
    if (op == 2'b10 && p > 3'd3) return 64'd0;
    for (int i = 0; i < lanes; i++) begin
      logic [63:0] x = (a >> (i*lw)) & m;
      logic [63:0] y = (b >> (i*lw)) & m;
      logic c;
      case (op)
        2'b00: r = r | (((x + y) & m) << (i*lw));
        2'b01: r = r | (((x - y) & m) << (i*lw));
        default: begin
          case (p)
            3'd0:    c = x > y;
            3'd1:    c = x == y;
            3'd2:    c = x <= y;
            default: c = x != y;
          endcase
          r[i] = c;
        end
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic w, input logic n, input logic [1:0] op,
                        input logic [2:0] p);
    @(negedge clk);
    op_a = a; op_b = b; wide_lanes = w; narrow = n; op_code = op; pred = p;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, model(a, b, w, n, op, p));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; wide_lanes = 1'b0; narrow = 1'b0;
    op_code = 2'b00; pred = 3'd0; op_a = '1; op_b = '1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 result after release", result, 64'd0);
  endtask

  task automatic t_add16;  // R3
    run_op("R3 add16 carry cut", 64'h0001_FFFF_8000_FFFF, 64'h0001_0001_8000_0001, 1'b0, 1'b0, 2'b00, 3'd0);
    run_op("R3 add16 mix", 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 2'b00, 3'd0);
  endtask

  task automatic t_add32;  // R4
    run_op("R4 add32 inner carry", 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b1, 1'b0, 2'b00, 3'd0);
    run_op("R4 add32 lane wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 1'b1, 1'b0, 2'b00, 3'd0);
    run_op("R4 sub32 inner borrow", 64'h0001_0000_0000_0000, 64'h0000_0001_0000_0001, 1'b1, 1'b0, 2'b01, 3'd0);
  endtask

  task automatic t_sub;  // R5
    run_op("R5 sub16 borrow cut", 64'h0000_0005_0000_0000, 64'h0001_0006_0001_0001, 1'b0, 1'b0, 2'b01, 3'd0);
    run_op("R5 sub16 plain", 64'h9000_7000_5000_3000, 64'h1000_1000_1000_1000, 1'b0, 1'b0, 2'b01, 3'd0);
  endtask

  task automatic t_narrow;  // R6
    run_op("R6 narrow add16", 64'hAAAA_BBBB_FFFF_0001, 64'h1111_2222_0001_FFFF, 1'b0, 1'b1, 2'b00, 3'd0);
    run_op("R6 narrow add32", 64'hAAAA_BBBB_0000_FFFF, 64'h1111_2222_0000_0001, 1'b1, 1'b1, 2'b00, 3'd0);
    run_op("R6 narrow sub32", 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 1'b1, 2'b01, 3'd0);
  endtask

  task automatic t_cmp16;  // R7 R8
    for (int p = 0; p < 4; p++) begin
      run_op("R7 R8 cmp16", 64'h8000_0005_0003_0007, 64'h7FFF_0005_0004_0007, 1'b0, 1'b0, 2'b10, p[2:0]);
    end
  endtask

  task automatic t_cmp32;  // R9
    for (int p = 0; p < 4; p++) begin
      run_op("R9 cmp32 low half decides", 64'h1234_0002_8000_0000, 64'h1234_0001_7FFF_FFFF, 1'b1, 1'b0, 2'b10, p[2:0]);
    end
    run_op("R9 cmp32 equal", 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 1'b1, 1'b0, 2'b10, 3'd1);
  endtask

  task automatic t_cmp_narrow;  // R10
    run_op("R10 narrow cmp16 le", 64'h0000_0000_0001_0002, 64'h0000_0000_0002_0002, 1'b0, 1'b1, 2'b10, 3'd2);
    run_op("R10 narrow cmp32 ne", 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 1'b1, 1'b1, 2'b10, 3'd3);
  endtask

  task automatic t_invalid;  // R11
    run_op("R11 op none", 64'h1234_5678_9ABC_DEF0, 64'h1, 1'b0, 1'b0, 2'b11, 3'd0);
    run_op("R11 bad pred", 64'h5, 64'h5, 1'b0, 1'b0, 2'b10, 3'd5);
  endtask

  task automatic t_hold;  // R2
    logic [63:0] held;
    run_op("R2 load", 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101, 1'b0, 1'b0, 2'b00, 3'd0);
    held = result;
    op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1; op_code = 2'b01;
    repeat (2) @(negedge clk);
    check("R2 hold result", result, held);
    check("R2 valid low", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_add16();
    t_add32();
    t_sub();
    t_narrow();
    t_cmp16();
    t_cmp32();
    t_cmp_narrow();
    t_invalid();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule